// File: doc/BRIEF.md
# Static Memory Bus Controller

This block turns one internal read or write request at a time into strobe waveforms for external asynchronous memories and memory-mapped peripherals. A request supplies a chip-select index, a byte address, write data, byte enables and a direction flag. The block then drives one of six active-low chip selects, the upper address bits, a separate read strobe and four shared lane pins. It also drives the outgoing half of the data bus with its enable. The pad ring joins the two halves of the data bus into the bidirectional bus.

Every chip select has its own settings, supplied on configuration inputs. These are the device width (8, 16 or 32 bits), byte-write or byte-select lane mode, setup, pulse and hold counts, a page-read enable and a shorter page-read pulse count. The lane pins change meaning with the width and the lane mode. An active-low wait input stretches the strobe. A slow-clock input replaces the programmed counts with a fixed set. Reads that stay within a 32-byte page take a shortened access.

Top module: `extMemBus`

## Requirements
- R1: Exactly one chip select `memCsN[reqCs]` is low for every cycle of an access, and it does not change during the access. All chip selects are high when idle. `memAddrHi` carries address bits 25:2 during the access.
- R2: An access starts the cycle after `reqValid` is sampled while idle. It spends S setup cycles, then P pulse cycles with the strobe low, then H hold cycles, so the chip select is low for S+P+H cycles. A pulse count of 0 acts as 1.
- R3: `reqReady` is high for exactly one cycle, the first cycle after the chip select rises. `reqValid` has no effect while an access is in progress.
- R4: Width code 0 (8-bit device): `memLane0` carries address bit 0 and `memLane2` carries address bit 1. `memLane1N` and `memLane3N` stay high. Data uses byte lane 0, taken from byte `addr[1:0]` of the request.
- R5: Width code 1 (16-bit device): `memLane2` carries address bit 1. `memLane0` is the active-low select of byte 0 of the addressed halfword, whose enables move down to lanes 0 and 1. Data uses lanes 0 and 1.
- R6: Width code 2 (32-bit device) in byte-write mode (`cfgByteSel` bit 0) gives each enabled lane its own write strobe. Lanes 0 to 3 drive `memWe0N`, `memLane1N`, `memLane2` and `memLane3N` low during the pulse. `memLane0` is the byte-0 select.
- R7: In byte-select mode (`cfgByteSel` bit 1) with a 16- or 32-bit device, `memWe0N` is one write-enable strobe for the whole word. The other lane pins are the active-low byte selects for the entire access.
- R8: While `memWaitN` is low the pulse phase cannot end. If wait is released after the W-th pulse cycle, the strobe lasts max(P, W) cycles.
- R9: When `slowMode` is high at the request, the access uses the fixed counts SLOW_SETUP=1, SLOW_PULSE=2 and SLOW_HOLD=1 in place of the programmed ones.
- R10: A page hit is a read to a chip select with page reads enabled, in the same 32-byte page (address bits 25:5) and chip select as the previous access. That previous access must also have been a page-enabled read without slow mode, and the current read must not be in slow mode. A page hit skips setup and hold and uses the page pulse count (0 acts as 1).
- R11: `memDoe` is high only during the chip-select cycles of a write. It is low throughout reads, so it is never high while `memRdN` is low.
- R12: Read data is captured at the last pulse cycle. From the ready cycle on, `rspRdata` holds the device lanes in use, shifted to the requested byte position, with the other bytes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Start pulse, sampled only while idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqCs | input | 3 | Chip-select index, 0 to 5 |
| reqAddr | input | 26 | Byte address |
| reqWdata | input | 32 | Write data, word aligned |
| reqBe | input | 4 | Byte enables |
| slowMode | input | 1 | Use the fixed slow waveform set |
| reqReady | output | 1 | One-cycle end-of-access pulse |
| rspRdata | output | 32 | Captured read data |
| cfgWidth | input | 12 | 2 bits per chip select: 0=8, 1=16, 2=32 |
| cfgByteSel | input | 6 | 1 = byte-select mode, 0 = byte-write mode |
| cfgSetup | input | 24 | 4-bit setup count per chip select |
| cfgPulse | input | 24 | 4-bit pulse count per chip select |
| cfgHold | input | 24 | 4-bit hold count per chip select |
| cfgPageEn | input | 6 | Page-read enable per chip select |
| cfgPagePulse | input | 24 | 4-bit page-hit pulse count per chip select |
| memCsN | output | 6 | Chip selects, active low |
| memAddrHi | output | 24 | Address bits 25:2 |
| memRdN | output | 1 | Read strobe |
| memWe0N | output | 1 | Lane-0 write strobe or word write enable |
| memLane0 | output | 1 | Address bit 0 or byte-0 select |
| memLane1N | output | 1 | Lane-1 write strobe or byte-1 select |
| memLane2 | output | 1 | Address bit 1, lane-2 write strobe or byte-2 select |
| memLane3N | output | 1 | Lane-3 write strobe or byte-3 select |
| memDout | output | 32 | Outgoing data |
| memDoe | output | 1 | Outgoing data enable |
| memDin | input | 32 | Incoming data |
| memWaitN | input | 1 | Wait request, active low |

## Verification
All pins come straight from registers that load on the accepting edge. The bench drives the one-cycle request at a falling edge and starts sampling at the next falling edge, which is the first chip-select cycle. It then counts low chip-select cycles and strobe cycles, one sample per cycle, until `reqReady` appears. That must be the first sample with every chip select high. Captured read data is checked in that same sample. Wait is released at the falling edge of the W-th observed strobe cycle, so the expected strobe length is max(P, W).

// File: rtl/extMemPkg.sv
package extMemPkg;
  localparam int LANES = 4;
  localparam int DATA_W = 8 * LANES;

  typedef enum logic [1:0] {WIDTH8 = 2'd0, WIDTH16 = 2'd1, WIDTH32 = 2'd2} busWidth_t;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_PULSE, PH_HOLD} phase_t;

  typedef struct packed {
    logic load;     // request accepted this cycle
    logic active;   // chip select asserted
    logic pulse;    // strobe phase
    logic capture;  // last read pulse cycle
  } ctrlStrobe_t;
endpackage

// File: rtl/extMemCtrl.sv
module extMemCtrl
  import extMemPkg::*;
#(
  parameter int NUM_CS = 6,
  parameter int CS_W = 3,
  parameter int CNT_W = 4,
  parameter int TAG_W = 21,
  parameter int SLOW_SETUP = 1,
  parameter int SLOW_PULSE = 2,
  parameter int SLOW_HOLD = 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic                    reqWrite,
  input  logic [CS_W-1:0]         reqCs,
  input  logic [TAG_W-1:0]        reqPage,
  input  logic                    slowMode,
  input  logic                    memWaitN,
  input  logic [CNT_W*NUM_CS-1:0] cfgSetup,
  input  logic [CNT_W*NUM_CS-1:0] cfgPulse,
  input  logic [CNT_W*NUM_CS-1:0] cfgHold,
  input  logic [NUM_CS-1:0]       cfgPageEn,
  input  logic [CNT_W*NUM_CS-1:0] cfgPagePulse,
  output ctrlStrobe_t             strb,
  output logic                    reqReady
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  phase_t phaseQ;
  logic [CNT_W-1:0] cntQ, pulseLenQ, holdLenQ;
  logic writeQ, readyQ;
  logic pageValidQ;
  logic [CS_W-1:0] pageCsQ;
  logic [TAG_W-1:0] pageTagQ;

  logic accept, pageHit, pulseLast;
  logic [CNT_W-1:0] selSetup, selPulse, selHold, selPage;
  logic [CNT_W-1:0] nextSetup, nextPulse, nextHold;

  always_comb begin
    selSetup = cfgSetup[reqCs*CNT_W +: CNT_W];
    selPulse = cfgPulse[reqCs*CNT_W +: CNT_W];
    selHold  = cfgHold[reqCs*CNT_W +: CNT_W];
    selPage  = cfgPagePulse[reqCs*CNT_W +: CNT_W];
    pageHit  = !reqWrite && !slowMode && cfgPageEn[reqCs] && pageValidQ
               && pageCsQ == reqCs && pageTagQ == reqPage;
    if (slowMode) begin
      nextSetup = CNT_W'(SLOW_SETUP);
      nextPulse = CNT_W'(SLOW_PULSE);
      nextHold  = CNT_W'(SLOW_HOLD);
    end else if (pageHit) begin
      nextSetup = '0;
      nextPulse = selPage;
      nextHold  = '0;
    end else begin
      nextSetup = selSetup;
      nextPulse = selPulse;
      nextHold  = selHold;
    end
    if (nextPulse == '0) nextPulse = ONE;
  end

  assign accept    = phaseQ == PH_IDLE && reqValid;
  assign pulseLast = phaseQ == PH_PULSE && cntQ == ONE && memWaitN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      cntQ <= '0;
      pulseLenQ <= '0;
      holdLenQ <= '0;
      writeQ <= 1'b0;
      readyQ <= 1'b0;
      pageValidQ <= 1'b0;
      pageCsQ <= '0;
      pageTagQ <= '0;
    end else begin
      readyQ <= 1'b0;
      unique case (phaseQ)
        PH_IDLE: if (accept) begin
          writeQ <= reqWrite;
          pulseLenQ <= nextPulse;
          holdLenQ <= nextHold;
          pageValidQ <= !reqWrite && !slowMode && cfgPageEn[reqCs];
          pageCsQ <= reqCs;
          pageTagQ <= reqPage;
          if (nextSetup != '0) begin
            phaseQ <= PH_SETUP;
            cntQ <= nextSetup;
          end else begin
            phaseQ <= PH_PULSE;
            cntQ <= nextPulse;
          end
        end
        PH_SETUP: if (cntQ == ONE) begin
          phaseQ <= PH_PULSE;
          cntQ <= pulseLenQ;
        end else cntQ <= cntQ - ONE;
        PH_PULSE: if (cntQ != ONE) cntQ <= cntQ - ONE;
          else if (memWaitN) begin
            if (holdLenQ != '0) begin
              phaseQ <= PH_HOLD;
              cntQ <= holdLenQ;
            end else begin
              phaseQ <= PH_IDLE;
              readyQ <= 1'b1;
            end
          end
        PH_HOLD: if (cntQ == ONE) begin
          phaseQ <= PH_IDLE;
          readyQ <= 1'b1;
        end else cntQ <= cntQ - ONE;
        default: phaseQ <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load    = accept;
    strb.active  = phaseQ != PH_IDLE;
    strb.pulse   = phaseQ == PH_PULSE;
    strb.capture = pulseLast && !writeQ;
  end
  assign reqReady = readyQ;

  // R8
  wait_stretch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_PULSE && !memWaitN) |=> phaseQ == PH_PULSE);
  // R3
  ready_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |=> !reqReady);
  // R3
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> phaseQ == PH_IDLE);
endmodule

// File: rtl/extMemPath.sv
module extMemPath
  import extMemPkg::*;
#(
  parameter int NUM_CS = 6,
  parameter int CS_W = 3,
  parameter int ADDR_W = 26
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strb,
  input  logic [CS_W-1:0]    reqCs,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]  reqWdata,
  input  logic [LANES-1:0]   reqBe,
  input  logic               reqWrite,
  input  logic [2*NUM_CS-1:0] cfgWidth,
  input  logic [NUM_CS-1:0]  cfgByteSel,
  output logic [DATA_W-1:0]  rspRdata,
  output logic [NUM_CS-1:0]  memCsN,
  output logic [ADDR_W-3:0]  memAddrHi,
  output logic               memRdN,
  output logic               memWe0N,
  output logic               memLane0,
  output logic               memLane1N,
  output logic               memLane2,
  output logic               memLane3N,
  output logic [DATA_W-1:0]  memDout,
  output logic               memDoe,
  input  logic [DATA_W-1:0]  memDin
);
  logic [CS_W-1:0] csQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, rdataQ;
  logic [LANES-1:0] beQ;
  logic writeQ;

  busWidth_t width;
  logic byteSel, wr;
  logic [1:0] shift;
  logic [4:0] bitShift;
  logic [LANES-1:0] beMask, devBe;
  logic [DATA_W-1:0] laneMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csQ <= '0; addrQ <= '0; wdataQ <= '0; beQ <= '0; writeQ <= 1'b0; rdataQ <= '0;
    end else begin
      if (strb.load) begin
        csQ <= reqCs; addrQ <= reqAddr; wdataQ <= reqWdata;
        beQ <= reqBe; writeQ <= reqWrite;
      end
      if (strb.capture) rdataQ <= (memDin & laneMask) << bitShift;
    end
  end

  always_comb begin
    width = busWidth_t'(cfgWidth[csQ*2 +: 2]);
    byteSel = cfgByteSel[csQ];
    unique case (width)
      WIDTH8:  begin shift = addrQ[1:0];       beMask = 4'b0001; laneMask = 32'h0000_00FF; end
      WIDTH16: begin shift = {addrQ[1], 1'b0}; beMask = 4'b0011; laneMask = 32'h0000_FFFF; end
      default: begin shift = 2'd0;             beMask = 4'b1111; laneMask = '1;           end
    endcase
    bitShift = {shift, 3'b000};
    devBe = (beQ >> shift) & beMask;
    wr = strb.active && strb.pulse && writeQ;

    memCsN = '1; memAddrHi = '0; memRdN = 1'b1; memDoe = 1'b0; memDout = '0;
    memWe0N = 1'b1; memLane0 = 1'b1; memLane1N = 1'b1; memLane2 = 1'b1; memLane3N = 1'b1;
    if (strb.active) begin
      memCsN = ~(NUM_CS'(1) << csQ);
      memAddrHi = addrQ[ADDR_W-1:2];
      memRdN = !(strb.pulse && !writeQ);
      memDoe = writeQ;
      memDout = (wdataQ >> bitShift) & laneMask;
      unique case (width)
        WIDTH8: begin
          memWe0N = !wr; memLane0 = addrQ[0]; memLane2 = addrQ[1];
        end
        WIDTH16: begin
          memLane0 = !devBe[0]; memLane2 = addrQ[1];
          memWe0N = byteSel ? !wr : !(wr && devBe[0]);
          memLane1N = byteSel ? !devBe[1] : !(wr && devBe[1]);
        end
        default: begin
          memLane0 = !devBe[0];
          memWe0N = byteSel ? !wr : !(wr && devBe[0]);
          memLane1N = byteSel ? !devBe[1] : !(wr && devBe[1]);
          memLane2 = byteSel ? !devBe[2] : !(wr && devBe[2]);
          memLane3N = byteSel ? !devBe[3] : !(wr && devBe[3]);
        end
      endcase
    end
  end
  assign rspRdata = rdataQ;

  // R1
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~memCsN) && (strb.active == (memCsN != '1)));
  // R1
  cs_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.active && $past(strb.active)) |-> $stable(memCsN) && $stable(memAddrHi));
  // R11
  oe_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memRdN |-> !memDoe);
  // R11
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memCsN == '1) |-> !memDoe);
endmodule

// File: rtl/extMemBus.sv
module extMemBus
  import extMemPkg::*;
#(
  parameter int NUM_CS = 6,
  parameter int CS_W = 3,
  parameter int ADDR_W = 26,
  parameter int CNT_W = 4,
  parameter int PAGE_BYTES = 32,
  parameter int SLOW_SETUP = 1,
  parameter int SLOW_PULSE = 2,
  parameter int SLOW_HOLD = 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic                    reqWrite,
  input  logic [CS_W-1:0]         reqCs,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [31:0]             reqWdata,
  input  logic [3:0]              reqBe,
  input  logic                    slowMode,
  output logic                    reqReady,
  output logic [31:0]             rspRdata,
  input  logic [2*NUM_CS-1:0]     cfgWidth,
  input  logic [NUM_CS-1:0]       cfgByteSel,
  input  logic [CNT_W*NUM_CS-1:0] cfgSetup,
  input  logic [CNT_W*NUM_CS-1:0] cfgPulse,
  input  logic [CNT_W*NUM_CS-1:0] cfgHold,
  input  logic [NUM_CS-1:0]       cfgPageEn,
  input  logic [CNT_W*NUM_CS-1:0] cfgPagePulse,
  output logic [NUM_CS-1:0]       memCsN,
  output logic [ADDR_W-3:0]       memAddrHi,
  output logic                    memRdN,
  output logic                    memWe0N,
  output logic                    memLane0,
  output logic                    memLane1N,
  output logic                    memLane2,
  output logic                    memLane3N,
  output logic [31:0]             memDout,
  output logic                    memDoe,
  input  logic [31:0]             memDin,
  input  logic                    memWaitN
);
  localparam int PAGE_LSB = $clog2(PAGE_BYTES);
  localparam int TAG_W = ADDR_W - PAGE_LSB;

  ctrlStrobe_t strb;

  extMemCtrl #(
    .NUM_CS(NUM_CS), .CS_W(CS_W), .CNT_W(CNT_W), .TAG_W(TAG_W),
    .SLOW_SETUP(SLOW_SETUP), .SLOW_PULSE(SLOW_PULSE), .SLOW_HOLD(SLOW_HOLD)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqCs(reqCs), .reqPage(reqAddr[ADDR_W-1:PAGE_LSB]), .slowMode(slowMode),
    .memWaitN(memWaitN), .cfgSetup(cfgSetup), .cfgPulse(cfgPulse), .cfgHold(cfgHold),
    .cfgPageEn(cfgPageEn), .cfgPagePulse(cfgPagePulse), .strb(strb), .reqReady(reqReady)
  );

  extMemPath #(.NUM_CS(NUM_CS), .CS_W(CS_W), .ADDR_W(ADDR_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .reqCs(reqCs), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqBe(reqBe), .reqWrite(reqWrite), .cfgWidth(cfgWidth),
    .cfgByteSel(cfgByteSel), .rspRdata(rspRdata), .memCsN(memCsN), .memAddrHi(memAddrHi),
    .memRdN(memRdN), .memWe0N(memWe0N), .memLane0(memLane0), .memLane1N(memLane1N),
    .memLane2(memLane2), .memLane3N(memLane3N), .memDout(memDout), .memDoe(memDoe),
    .memDin(memDin)
  );
endmodule

// File: tb/sim_extMemBus.sv
module sim_extMemBus;
  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqWrite = 0, slowMode = 0, memWaitN = 1;
  logic [2:0] reqCs = 0;
  logic [25:0] reqAddr = 0;
  logic [31:0] reqWdata = 0, memDin = 0;
  logic [3:0] reqBe = 0;
  logic reqReady;
  logic [31:0] rspRdata, memDout;
  logic [11:0] cfgWidth;
  logic [5:0] cfgByteSel, cfgPageEn;
  logic [23:0] cfgSetup, cfgPulse, cfgHold, cfgPagePulse;
  logic [5:0] memCsN;
  logic [23:0] memAddrHi;
  logic memRdN, memWe0N, memLane0, memLane1N, memLane2, memLane3N, memDoe;

  int checks = 0, failures = 0;
  int widthA[6] = '{0, 1, 2, 1, 2, 0};
  bit bselA[6] = '{0, 0, 0, 1, 1, 1};
  int setupA[6], pulseA[6], holdA[6], pageA[6];
  bit pgValid = 0;
  int pgCs = 0;
  logic [20:0] pgTag = 0;

  always #5 clk = ~clk;

  extMemBus u0 (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] expPins(int w, bit bs, bit ws, logic [25:0] a, logic [3:0] be);
    logic [1:0] sh;
    logic [3:0] db;
    sh = (w == 0) ? a[1:0] : (w == 1) ? {a[1], 1'b0} : 2'd0;
    db = (be >> sh) & ((w == 0) ? 4'd1 : (w == 1) ? 4'd3 : 4'd15);
    if (w == 0) return {!ws, a[0], 1'b1, a[1], 1'b1};
    if (w == 1) return bs ? {!ws, !db[0], !db[1], a[1], 1'b1}
                          : {!(ws && db[0]), !db[0], !(ws && db[1]), a[1], 1'b1};
    return bs ? {!ws, !db[0], !db[1], !db[2], !db[3]}
              : {!(ws && db[0]), !db[0], !(ws && db[1]), !(ws && db[2]), !(ws && db[3])};
  endfunction

  task automatic runAccess(input bit wr, input int cs, input logic [25:0] a,
                           input logic [31:0] wd, input logic [3:0] be,
                           input int waitW, input bit slow, input bit poke, input string tag);
    int w = widthA[cs], s, p, h, pe, csCnt = 0, stCnt = 0, pinBad = 0, oeBad = 0;
    bit bs = bselA[cs], hit, prevLow = 0, readyOk = 0, done = 0, pokeNow = 0;
    logic [1:0] sh;
    logic [31:0] mask, din, expRd;
    sh = (w == 0) ? a[1:0] : (w == 1) ? {a[1], 1'b0} : 2'd0;
    mask = (w == 0) ? 32'hFF : (w == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    hit = !wr && !slow && (pageA[cs] >= 0) && cfgPageEn[cs] && pgValid && pgCs == cs && pgTag == a[25:5];
    if (slow) begin s = 1; p = 2; h = 1; end
    else if (hit) begin s = 0; p = (pageA[cs] == 0) ? 1 : pageA[cs]; h = 0; end
    else begin s = setupA[cs]; p = (pulseA[cs] == 0) ? 1 : pulseA[cs]; h = holdA[cs]; end
    pe = (waitW > p) ? waitW : p;
    pgValid = !wr && !slow && cfgPageEn[cs]; pgCs = cs; pgTag = a[25:5];
    din = $urandom;
    expRd = (din & mask) << {sh, 3'b000};
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqCs = 3'(cs); reqAddr = a; reqWdata = wd; reqBe = be;
    slowMode = slow; memWaitN = (waitW == 0); memDin = din;
    @(negedge clk);
    reqValid = 0;
    for (int cyc = 0; cyc < 100 && !done; cyc++) begin
      bit low, st;
      if (pokeNow) begin reqValid = 0; reqCs = 3'(cs); pokeNow = 0; end
      low = memCsN != 6'h3F;
      st = wr ? (!memWe0N || (w != 0 && !bs && (!memLane1N || (w == 2 && (!memLane2 || !memLane3N)))))
              : !memRdN;
      if (low) begin
        csCnt++;
        if (memCsN != ~(6'd1 << cs) || memAddrHi != a[25:2]) pinBad++;
        if ({memWe0N, memLane0, memLane1N, memLane2, memLane3N} != expPins(w, bs, wr && st, a, be)) pinBad++;
        if (memDoe != wr) oeBad++;
        if (wr && ((memDout & mask) != ((wd >> {sh, 3'b000}) & mask))) pinBad++;
        if (wr && !memRdN) pinBad++;
      end else if (memDoe) oeBad++;
      if (st) begin
        stCnt++;
        if (waitW > 0 && stCnt == waitW) memWaitN = 1;
        if (poke && stCnt == 1) begin reqValid = 1; reqCs = 3'((cs + 1) % 6); pokeNow = 1; end
      end
      if (reqReady) begin
        done = 1;
        readyOk = prevLow && !low;
        if (!wr) check(rspRdata == expRd, "R12", {tag, " read data"}, rspRdata, expRd);
      end
      prevLow = low;
      if (!done) @(negedge clk);
    end
    check(done && readyOk, "R3", {tag, " ready timing"}, readyOk, 1);
    check(csCnt == s + pe + h, slow ? "R9" : hit ? "R10" : "R2", {tag, " cs low cycles"}, csCnt, s + pe + h);
    check(stCnt == pe, waitW > 0 ? "R8" : "R2", {tag, " strobe cycles"}, stCnt, pe);
    check(pinBad == 0, w == 0 ? "R4" : w == 1 ? "R5" : bs ? "R7" : "R6", {tag, " pins"}, pinBad, 0);
    check(oeBad == 0, "R11", {tag, " output enable"}, oeBad, 0);
    memWaitN = 1;
    if (poke) begin
      int extra = 0;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        if (memCsN != 6'h3F || reqReady) extra++;
      end
      check(extra == 0, "R3", {tag, " busy request ignored"}, extra, 0);
    end
  endtask

  function automatic logic [3:0] legalBe(int w, logic [25:0] a);
    if (w == 0) return 4'd1 << a[1:0];
    if (w == 1) return 4'(($urandom % 3) + 1) << {a[1], 1'b0};
    return 4'(($urandom % 15) + 1);
  endfunction

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 6; i++) begin
      setupA[i] = $urandom % 4; pulseA[i] = $urandom % 5; holdA[i] = $urandom % 4;
      pageA[i] = $urandom % 3;
    end
    setupA[2] = 2; pulseA[2] = 3; holdA[2] = 1; pageA[2] = 1;
    pulseA[0] = 0;
    for (int i = 0; i < 6; i++) begin
      cfgWidth[i*2 +: 2] = 2'(widthA[i]); cfgByteSel[i] = bselA[i];
      cfgSetup[i*4 +: 4] = 4'(setupA[i]); cfgPulse[i*4 +: 4] = 4'(pulseA[i]);
      cfgHold[i*4 +: 4] = 4'(holdA[i]); cfgPagePulse[i*4 +: 4] = 4'(pageA[i]);
    end
    cfgPageEn = 6'b010100;
    repeat (3) @(negedge clk);
    check(memCsN == 6'h3F && memRdN && !memDoe && !reqReady, "R1", "reset idle", memCsN, 6'h3F);
    rstN = 1;
    @(negedge clk);
    // R4 R5 R6 R7: one write and one read per chip select
    for (int c = 0; c < 6; c++) begin
      logic [25:0] a = 26'($urandom) | 26'h3;
      runAccess(1, c, a, $urandom, legalBe(widthA[c], a), 0, 0, 0, "dir write");
      a = 26'($urandom);
      runAccess(0, c, a, 0, legalBe(widthA[c], a), 0, 0, 0, "dir read");
    end
    // R8: wait stretch past the programmed pulse
    runAccess(0, 2, 26'h100, 0, 4'hF, 7, 0, 0, "wait read");
    runAccess(1, 4, 26'h204, 32'hA5A5_5A5A, 4'b1001, 5, 0, 0, "wait write");
    // R9: slow waveform set
    runAccess(0, 1, 26'h302, 0, 4'b1100, 0, 1, 0, "slow read");
    runAccess(1, 3, 26'h040, 32'h1234_5678, 4'b0011, 0, 1, 0, "slow write");
    // R10: page hit, then write breaks the page
    runAccess(0, 2, 26'h1000, 0, 4'hF, 0, 0, 0, "page first");
    runAccess(0, 2, 26'h101C, 0, 4'hF, 0, 0, 0, "page hit");
    runAccess(0, 2, 26'h1020, 0, 4'hF, 0, 0, 0, "page other");
    runAccess(1, 2, 26'h1020, 32'hDEAD_BEEF, 4'hF, 0, 0, 0, "page write");
    runAccess(0, 2, 26'h1024, 0, 4'hF, 0, 0, 0, "page after write");
    runAccess(0, 2, 26'h1028, 0, 4'hF, 3, 0, 0, "page hit wait");
    // R3: request during access ignored
    runAccess(1, 5, 26'h0AA, 32'hCAFE_F00D, legalBe(0, 26'h0AA), 0, 0, 1, "poke");
    for (int n = 0; n < 150; n++) begin
      int c = $urandom % 6;
      logic [25:0] a = 26'($urandom);
      if (($urandom % 3) == 0 && c == 2) a = {pgTag, 5'($urandom)};
      runAccess(1'($urandom), c, a, $urandom, legalBe(widthA[c], a),
                (($urandom % 3) == 0) ? int'($urandom % 6) : 0, ($urandom % 8) == 0, 0, "random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    check(0, "R2", "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule